// File: doc/BRIEF.md
# Per-Channel Short-Circuit Diagnostic Sequencer

This block sits beside one audio output channel and decides when that channel is switched off and on again after its short-circuit protection trips. It takes the protection comparator's overload flag, three decoded short-class flags from the analog measurement, a permanent-diagnostic enable, a 1 ms tick and a host read pulse. It drives the channel shutdown control and holds a fault record that the status bytes report.

With diagnostics off, a tripped channel is held off and re-checked on every tick until the overload clears. With diagnostics on and a cycle armed, the first tick check acts as a deglitch filter. A short overload lets the channel resume at once. An overload that persists starts a long diagnostic cycle of `CYC_MS` ticks, and during that cycle a fault class is kept only if it holds on every clock. When the cycle ends, the single highest-priority surviving fault goes into the record, a terminated flag is set, and the channel falls back to restart behaviour. The record stays until the host reads it. That read clears the record and arms the next cycle, so the value read always belongs to the cycle before, and a cleared fault shows up only on the second read. A result loaded from the turn-on diagnostic stays in the record until a permanent cycle captures a stable short.

Top module: `scd_seq`

## Requirements
- R1: After reset, shut_o, done_o and perm_o are 0, rec_o is 0, and a diagnostic cycle is armed.
- R2: When ovl_i is 1 while the channel is running (shut_o = 0), shut_o is 1 on the next clock.
- R3: A shut channel is released only on a clock where tick_i = 1 and ovl_i = 0, and shut_o is 0 on the following clock. With diag_en_i = 0, or with no cycle armed, the channel stays shut on each tick while ovl_i = 1.
- R4: With diag_en_i = 1 and a cycle armed, if ovl_i is 0 at the first tick after the trip, the channel resumes and no cycle runs: done_o and rec_o do not change.
- R5: If ovl_i is 1 at that first tick, with diag_en_i = 1 and a cycle armed, a cycle starts and ends on its CYC_MS-th tick. The channel stays shut throughout and on the clock after the end. Once the cycle ends, it is released only by the restart rule of R3.
- R6: fault_i bit 0 is short to ground, bit 1 is short to supply and bit 2 is shorted load. A class is captured only if its bit is 1 on every clock of the cycle, including the clock of the closing tick. Of the captured classes, only the lowest bit index is stored, as a one-hot value in rec_o[2:0], and perm_o is set to 1.
- R7: A cycle that ends with no stable class leaves rec_o and perm_o unchanged, but still sets done_o.
- R8: done_o is set on the clock after a cycle ends and holds until read_i. No new cycle can start until read_i has pulsed. read_i clears rec_o, perm_o and done_o and arms the next cycle.
- R9: ton_load_i writes ton_fault_i (bit 3 = open load, bits 2:0 as in R6) into rec_o with perm_o = 0. That value stays until a read clears it or a permanent cycle stores a stable class.
- R10: When a cycle ends in the same clock as read_i, the cycle end wins. done_o is 1, no cycle is armed, and any stable class captured by the cycle is stored in rec_o. A ton_load_i in the same clock as a read also wins over the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovl_i | input | 1 | Overload flag from the short-circuit protection |
| fault_i | input | NSHORT | Decoded short classes (bit 0 ground, 1 supply, 2 load) |
| diag_en_i | input | 1 | Permanent diagnostic enable |
| tick_i | input | 1 | One-clock pulse every 1 ms |
| read_i | input | 1 | Host read of the status bytes done (pulse) |
| ton_load_i | input | 1 | Load the turn-on diagnostic result |
| ton_fault_i | input | NSHORT+1 | Turn-on result (bit 3 open load) |
| shut_o | output | 1 | Channel shutdown |
| rec_o | output | NSHORT+1 | Latched fault record |
| perm_o | output | 1 | Record comes from a permanent cycle |
| done_o | output | 1 | Diagnostic cycle terminated |

## Verification
The overlap that matters is a host read landing on the same clock as the closing tick of a diagnostic cycle. In that case the read's clear-and-arm competes with the cycle's store-and-disarm. The bench sets this up with a directed case in which the read pulse goes out with the last tick of a cycle that has a stable shorted-load class. It then requires done_o = 1, the new one-hot record, and no new cycle on the next overload. The random phase hits the same collision and the turn-on-load/read overlap many times, and every clock is judged against a bench model of the requirements.

// File: rtl/scd_pkg.sv
package scd_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RST  = 2'd2,
    ST_CYC  = 2'd3
  } scd_st_e;

  localparam int FLT_GND  = 0;
  localparam int FLT_VS   = 1;
  localparam int FLT_LOAD = 2;
endpackage

// File: rtl/scd_tick_cnt.sv
module scd_tick_cnt #(
  parameter int CYC_MS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CNT_W = (CYC_MS > 1) ? $clog2(CYC_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_MS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/scd_fault_acc.sv
module scd_fault_acc #(
  parameter int NSHORT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [NSHORT-1:0] fault_i,
  output logic [NSHORT-1:0] stable_o
);
  logic [NSHORT-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '1;
    else if (clr_i)  mask_q <= '1;
    else if (en_i)   mask_q <= mask_q & fault_i;
  end

  // includes the current clock so the closing tick must also see the class
  assign stable_o = mask_q & fault_i;
endmodule

// File: rtl/scd_prio_pick.sv
module scd_prio_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] pick_o
);
  logic [N:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign pick_o[i]  = req_i[i] & ~below[i];
    assign below[i+1] = below[i] | req_i[i];
  end
endmodule

// File: rtl/scd_seq.sv
module scd_seq
  import scd_pkg::*;
#(
  parameter int NSHORT = 3,
  parameter int CYC_MS = 100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ovl_i,
  input  logic [NSHORT-1:0] fault_i,
  input  logic            diag_en_i,
  input  logic            tick_i,
  input  logic            read_i,
  input  logic            ton_load_i,
  input  logic [NSHORT:0] ton_fault_i,
  output logic            shut_o,
  output logic [NSHORT:0] rec_o,
  output logic            perm_o,
  output logic            done_o
);
  localparam int REC_W = NSHORT + 1;

  scd_st_e st_q, st_d;
  logic armed_q;
  logic start_cyc, in_cyc, cyc_end;
  logic [NSHORT-1:0] stable, pick;
  logic [REC_W-1:0] rec_q;
  logic perm_q, done_q;

  assign in_cyc    = (st_q == ST_CYC);
  assign start_cyc = (st_q == ST_WAIT) && tick_i && ovl_i && diag_en_i && armed_q;

  scd_tick_cnt #(.CYC_MS(CYC_MS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_cyc),
    .en_i  (in_cyc && tick_i),
    .last_o(cyc_end)
  );

  scd_fault_acc #(.NSHORT(NSHORT)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_cyc),
    .en_i    (in_cyc),
    .fault_i (fault_i),
    .stable_o(stable)
  );

  scd_prio_pick #(.N(NSHORT)) u_pick (
    .req_i (stable),
    .pick_o(pick)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:  if (ovl_i) st_d = ST_WAIT;
      ST_WAIT: if (tick_i) begin
                 if (!ovl_i)         st_d = ST_RUN;
                 else if (start_cyc) st_d = ST_CYC;
                 else                st_d = ST_RST;
               end
      ST_RST:  if (tick_i && !ovl_i) st_d = ST_RUN;
      ST_CYC:  if (cyc_end) st_d = ST_RST;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  // cycle end outranks turn-on load, which outranks the read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q   <= '0;
      perm_q  <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (cyc_end && (|pick)) begin
        rec_q  <= {1'b0, pick};
        perm_q <= 1'b1;
      end else if (ton_load_i) begin
        rec_q  <= ton_fault_i;
        perm_q <= 1'b0;
      end else if (read_i) begin
        rec_q  <= '0;
        perm_q <= 1'b0;
      end
      if (cyc_end) begin
        done_q  <= 1'b1;
        armed_q <= 1'b0;
      end else if (read_i) begin
        done_q  <= 1'b0;
        armed_q <= 1'b1;
      end
    end
  end

  assign shut_o = (st_q != ST_RUN);
  assign rec_o  = rec_q;
  assign perm_o = perm_q;
  assign done_o = done_q;
endmodule

// File: rtl/scd_seq_chk.sv
module scd_seq_chk #(
  parameter int REC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ovl_i,
  input logic             tick_i,
  input logic             read_i,
  input logic             ton_load_i,
  input logic             cyc_end,
  input logic             shut_o,
  input logic [REC_W-1:0] rec_o,
  input logic             perm_o,
  input logic             done_o
);
  AST_SHUT_ON_OVL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovl_i && !shut_o |=> shut_o); // R2

  AST_RELEASE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shut_o) |-> $past(tick_i) && !$past(ovl_i)); // R3

  AST_SHUT_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end |=> shut_o && done_o); // R5

  AST_PERM_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_o |-> $countones(rec_o) == 1 && !rec_o[REC_W-1]); // R6

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !read_i |=> done_o); // R8

  AST_READ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i && !cyc_end && !ton_load_i |=> rec_o == '0 && !done_o && !perm_o); // R8

  AST_END_OVER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end && read_i |=> done_o); // R10
endmodule

bind scd_seq scd_seq_chk #(.REC_W(NSHORT + 1)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ovl_i     (ovl_i),
  .tick_i    (tick_i),
  .read_i    (read_i),
  .ton_load_i(ton_load_i),
  .cyc_end   (cyc_end),
  .shut_o    (shut_o),
  .rec_o     (rec_o),
  .perm_o    (perm_o),
  .done_o    (done_o)
);

// File: tb/tb_scd_seq.sv
`timescale 1ns/1ps
module tb_scd_seq;
  localparam int CYC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovl = 1'b0, de = 1'b0, tick = 1'b0, rd = 1'b0, tl = 1'b0;
  logic [2:0] flt = '0;
  logic [3:0] tf = '0;
  logic shut, perm, done;
  logic [3:0] rec;

  int checks = 0, errors = 0;

  // requirement model
  int m_st = 0;  // 0 run, 1 wait, 2 restart, 3 cycle
  int m_cnt = 0;
  logic [2:0] m_mask = '1;
  logic [3:0] m_rec = '0;
  logic m_perm = 0, m_done = 0, m_armed = 1;

  always #2.5 clk = ~clk;

  scd_seq #(.NSHORT(3), .CYC_MS(CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ovl_i(ovl), .fault_i(flt), .diag_en_i(de),
    .tick_i(tick), .read_i(rd), .ton_load_i(tl), .ton_fault_i(tf),
    .shut_o(shut), .rec_o(rec), .perm_o(perm), .done_o(done)
  );

  function automatic logic [2:0] prio(input logic [2:0] v);
    if (v[0]) return 3'b001;
    if (v[1]) return 3'b010;
    if (v[2]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit endc;
    logic [2:0] pk;
    int nst;
    endc = (m_st == 3) && tick && (m_cnt == CYC - 1);
    pk = prio(m_mask & flt);
    nst = m_st;
    case (m_st)
      0: if (ovl) nst = 1;
      1: if (tick) begin
           if (!ovl) nst = 0;
           else if (de && m_armed) begin nst = 3; m_cnt = 0; m_mask = '1; end
           else nst = 2;
         end
      2: if (tick && !ovl) nst = 0;
      default: begin
        m_mask = m_mask & flt;
        if (tick) begin
          if (endc) nst = 2; else m_cnt++;
        end
      end
    endcase
    if (endc && pk != 0) begin m_rec = {1'b0, pk}; m_perm = 1; end
    else if (tl) begin m_rec = tf; m_perm = 0; end
    else if (rd) begin m_rec = '0; m_perm = 0; end
    if (endc) begin m_done = 1; m_armed = 0; end
    else if (rd) begin m_done = 0; m_armed = 1; end
    m_st = nst;
  endtask

  task automatic step(input logic o, input logic [2:0] f, input logic t,
                      input logic r = 0, input logic l = 0, input logic [3:0] lf = '0);
    @(negedge clk);
    ovl = o; flt = f; tick = t; rd = r; tl = l; tf = lf;
    @(posedge clk);
    model_edge();
    #1;
    chk(shut === (m_st != 0), "R3/R5 shut_o", shut, m_st != 0);
    chk(rec === m_rec && perm === m_perm, "R6/R9 rec_o", {perm, rec}, {m_perm, m_rec});
    chk(done === m_done, "R8 done_o", done, m_done);
  endtask

  // run one full diagnostic cycle with a constant fault pattern; last tick may carry a read
  task automatic run_cycle(input logic [2:0] f, input logic rd_last);
    step(1, f, 0);
    step(1, f, 1);          // first tick: cycle starts
    for (int i = 0; i < CYC - 1; i++) step(1, f, 1);
    step(1, f, 1, rd_last); // closing tick
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(shut === 0 && done === 0 && perm === 0 && rec === 0, "R1 reset state",
        {shut, done, perm, rec}, 0);

    // R2 / R4: trip then deglitch release with diag enabled
    de = 1;
    step(1, 3'b000, 0);
    chk(shut === 1, "R2 shut after overload", shut, 1);
    step(1, 3'b000, 0);
    step(0, 3'b000, 1);
    chk(shut === 0 && done === 0 && rec === 0, "R4 deglitch resume", {shut, done, rec}, 0);

    // R3: restart mode
    de = 0;
    step(1, 3'b001, 0);
    step(1, 3'b001, 1);
    step(1, 3'b001, 1);
    chk(shut === 1, "R3 held while overload", shut, 1);
    step(0, 3'b000, 0);
    chk(shut === 1, "R3 no release without tick", shut, 1);
    step(0, 3'b000, 1);
    chk(shut === 0 && done === 0, "R3 release at tick", {shut, done}, 0);

    // R5 / R6: cycle with ground dropped for one clock
    de = 1;
    step(1, 3'b011, 0);
    step(1, 3'b011, 1);
    step(1, 3'b011, 0);
    step(1, 3'b010, 0);
    for (int i = 0; i < CYC; i++) step(1, 3'b011, 1);
    chk(rec === 4'b0010 && perm === 1 && done === 1 && shut === 1, "R5 R6 cycle result",
        {shut, done, perm, rec}, {3'b111, 4'b0010});
    step(0, 3'b000, 1);
    chk(shut === 0, "R5 restart release", shut, 0);

    // R8: not armed -> restart, record held; two reads
    step(1, 3'b001, 0);
    step(1, 3'b001, 1);
    step(1, 3'b001, 1);
    step(0, 3'b000, 1);
    chk(done === 1 && rec === 4'b0010, "R8 no cycle before read", {done, rec}, {1'b1, 4'b0010});
    step(0, 3'b000, 0, 1);
    chk(done === 0 && rec === 0 && perm === 0, "R8 read clears", {done, perm, rec}, 0);

    // R9 / R7: turn-on record survives a cycle with no stable class
    step(0, 3'b000, 0, 0, 1, 4'b1000);
    chk(rec === 4'b1000 && perm === 0, "R9 turn-on load", {perm, rec}, 4'b1000);
    run_cycle(3'b000, 0);
    chk(done === 1 && rec === 4'b1000 && perm === 0, "R7 R9 record kept",
        {done, perm, rec}, {1'b1, 1'b0, 4'b1000});
    step(0, 3'b000, 1, 1);

    // R6: multiple faults, lowest index first, rest later
    run_cycle(3'b111, 0);
    chk(rec === 4'b0001 && perm === 1, "R6 priority ground", rec, 4'b0001);
    step(0, 3'b000, 1, 1);
    run_cycle(3'b110, 0);
    chk(rec === 4'b0010, "R6 next fault after read", rec, 4'b0010);
    step(0, 3'b000, 1, 1);

    // R10: read on the closing tick
    run_cycle(3'b100, 1);
    chk(done === 1 && rec === 4'b0100, "R10 end wins over read", {done, rec}, {1'b1, 4'b0100});
    step(1, 3'b100, 0);
    step(1, 3'b100, 1);
    step(1, 3'b100, 1);
    step(1, 3'b100, 1);
    chk(done === 1 && rec === 4'b0100, "R10 not armed after collision", {done, rec}, {1'b1, 4'b0100});
    step(0, 3'b000, 1, 1);

    // random phase
    for (int n = 0; n < 6000; n++) begin
      logic o, t, r, l;
      logic [2:0] f;
      logic [3:0] lf;
      if ((n % 500) == 0) de = $urandom_range(0, 3) != 0;
      o  = $urandom_range(0, 9) < 6;
      f  = ($urandom_range(0, 9) < 8) ? 3'($urandom_range(1, 7)) : 3'b000;
      t  = $urandom_range(0, 3) == 0;
      r  = $urandom_range(0, 29) == 0;
      l  = $urandom_range(0, 99) == 0;
      lf = 4'($urandom);
      step(o, f, t, r, l, lf);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule